// File: doc/BRIEF.md
# Integer Execute Unit with Trapping Overflow

This block is the arithmetic and logic stage of a small 32-bit load/store integer pipeline. Once an instruction has been decoded, the unit receives two register operands, the raw 16-bit immediate field, a 5-bit shift count, an operation code and a write request. In the same cycle it returns the 32-bit result, the register write enable, and a flag that reports signed overflow. The unit has no clock and holds no state.

The unit extends the immediate itself. A logical immediate gets zero-extension and an arithmetic immediate gets sign-extension. The immediate-load form places the field in the upper half of the word. The signed forms (add, subtract, add-immediate) are trapping: when they overflow, the flag goes high and the register write is withheld. The unsigned forms wrap and never flag. The pipeline uses the flag to start its own exception handling. That handling is outside this block.

Top module: `ex_alu_unit`

## Requirements
- R1: The operation codes on `op_sel` are 1 add, 2 addu, 3 sub, 4 subu, 5 and, 6 or, 7 xor, 8 nor, 9 sll, 10 addi, 11 addiu, 12 andi, 13 ori, 14 xori and 15 lui. For add and addu, `result` is `opnd_a + opnd_b` modulo 2^32.
- R2: For sub and subu, `result` is `opnd_a - opnd_b` modulo 2^32.
- R3: For add and addi, `ovf` is 1 exactly when both addends have the same sign and the sum has the other sign. When `ovf` is 1, `wr_en` is 0.
- R4: For sub, `ovf` is 1 exactly when the operand signs differ and the sign of the difference differs from `opnd_a`. When `ovf` is 1, `wr_en` is 0.
- R5: addu, subu and addiu never set `ovf`, and their `wr_en` equals `wr_req` for every operand value.
- R6: and, or, xor and nor combine `opnd_a` with `opnd_b` bitwise. nor gives `~(opnd_a | opnd_b)`.
- R7: andi, ori and xori combine `opnd_a` with `imm_val` zero-extended to 32 bits, and they ignore `opnd_b`.
- R8: addi and addiu add `opnd_a` to `imm_val` sign-extended from bit 15, and they ignore `opnd_b`.
- R9: sll gives `opnd_b` shifted left by `shamt` (0 to 31), with zeros shifted in.
- R10: lui gives `{imm_val, 16'h0000}`, and it ignores `opnd_a` and `opnd_b`.
- R11: Code 0 and codes 16 to 31 are unrecognised. They give `result` = 0, `wr_en` = 0 and `ovf` = 0.
- R12: For every recognised operation without overflow, `wr_en` equals `wr_req`. `ovf` does not depend on `wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (see R1) |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand; the value that sll shifts |
| imm_val | input | 16 | Raw immediate field |
| shamt | input | 5 | Shift count for sll |
| wr_req | input | 1 | Decoder asks for a register write |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Register write enable after overflow cancellation |
| ovf | output | 1 | Signed overflow on a trapping operation |

## Verification
The hardest conditions to reach are the overflow boundaries: the most negative value minus one, the most positive value plus one, and subtracting the most negative value from zero. These sit right beside operand pairs that do not overflow, and random operands seldom land on them. Directed tasks therefore drive each boundary pair and its neighbour through the signed form and then through the unsigned form. A bench-side 64-bit reference decides the expected flag and write enable for each pair. The sign-extended immediate path also gets `0x8000` and `0x7FFF` against extreme values of `opnd_a`, so that addi overflow is forced through the immediate.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and logic-function selector for the
// execute unit. Assumes a 5-bit operation code with 0 and 16..31 unused.
package alu_pkg;

    typedef enum logic [4:0] {
        OP_NONE  = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADDU  = 5'd2,
        OP_SUB   = 5'd3,
        OP_SUBU  = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_NOR   = 5'd8,
        OP_SLL   = 5'd9,
        OP_ADDI  = 5'd10,
        OP_ADDIU = 5'd11,
        OP_ANDI  = 5'd12,
        OP_ORI   = 5'd13,
        OP_XORI  = 5'd14,
        OP_LUI   = 5'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [2:0] {
        RS_ZERO  = 3'd0,
        RS_ARITH = 3'd1,
        RS_LOGIC = 3'd2,
        RS_SHIFT = 3'd3,
        RS_UPPER = 3'd4
    } res_src_e;

endpackage

// File: rtl/alu_opnd_sel.sv
// Module: alu_opnd_sel
// Builds the second operand for the datapath. Logical-immediate forms get
// a zero-extended immediate, arithmetic-immediate forms a sign-extended
// one, and register forms pass opnd_b through. It also produces the
// upper-half placement of the immediate. Assumes DATA_W > IMM_W.
module alu_opnd_sel
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [IMM_W-1:0]    imm,
    output logic [DATA_W-1:0]   b_eff,
    output logic [DATA_W-1:0]   upper_val
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_zext;
    logic [DATA_W-1:0] imm_sext;

    assign imm_zext  = {{PAD_W{1'b0}}, imm};
    assign imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign upper_val = {imm, {PAD_W{1'b0}}};

    // Choose the operand source by immediate class.
    always_comb begin
        unique case (op)
            OP_ANDI, OP_ORI, OP_XORI: b_eff = imm_zext;
            OP_ADDI, OP_ADDIU:        b_eff = imm_sext;
            default:                  b_eff = opnd_b;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// A single adder that does both addition and subtraction (subtract =
// add inverted operand plus one), with a raw two's-complement overflow
// indication. Assumes the caller decides whether the overflow matters.
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_inv;
    logic [DATA_W:0]   wide;

    assign b_inv = sub ? ~b : b;

    // Ripple-free behavioural add with carry-in from the subtract select.
    always_comb begin
        wide = {1'b0, a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, sub};
        sum  = wide[DATA_W-1:0];
    end

    // Same-sign inputs producing opposite-sign output means overflow.
    assign ovf_raw = (a[MSB] == b_inv[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Bitwise and/or/xor/nor of two words, selected by a 2-bit function.
module alu_logic
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_fn_e         fn,
    output logic [DATA_W-1:0] y
);
    // Apply the selected bitwise function.
    always_comb begin
        unique case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
// Module: alu_shift
// Logarithmic left shifter: stage k shifts by 2**k when shamt bit k is
// set, and zeros fill the vacated positions. Assumes SH_W = clog2(DATA_W).
module alu_shift #(
    parameter int DATA_W = 32,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amount,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [0:SH_W];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        // One conditional power-of-two shift per stage.
        assign stage[k+1] = amount[k] ? {stage[k][DATA_W-1-STEP:0], {STEP{1'b0}}}
                                      : stage[k];
    end

    assign dout = stage[SH_W];
endmodule

// File: rtl/ex_alu_unit.sv
// Module: ex_alu_unit (top)
// Combinational execute stage. Decodes the operation code into datapath
// controls, runs the adder, logic unit and shifter in parallel, and picks
// one result. Trapping forms (add, sub, addi) that overflow raise ovf and
// cancel the write. Unrecognised codes give zero with no write.
// Assumes operands are already read from the register file.
module ex_alu_unit
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input  logic [4:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [SH_W-1:0]   shamt,
    input  logic              wr_req,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              ovf
);
    alu_op_e           op;
    res_src_e          src;
    logic_fn_e         lfn;
    logic              do_sub;
    logic              traps;
    logic              valid;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] upper_val;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] shift_y;
    logic              ovf_raw;

    assign op = alu_op_e'(op_sel);

    // Decode the operation code into datapath controls.
    always_comb begin
        src    = RS_ZERO;
        lfn    = LF_AND;
        do_sub = 1'b0;
        traps  = 1'b0;
        valid  = 1'b1;
        unique case (op)
            OP_ADD:   begin src = RS_ARITH; traps = 1'b1; end
            OP_ADDU:  src = RS_ARITH;
            OP_SUB:   begin src = RS_ARITH; do_sub = 1'b1; traps = 1'b1; end
            OP_SUBU:  begin src = RS_ARITH; do_sub = 1'b1; end
            OP_ADDI:  begin src = RS_ARITH; traps = 1'b1; end
            OP_ADDIU: src = RS_ARITH;
            OP_AND, OP_ANDI: begin src = RS_LOGIC; lfn = LF_AND; end
            OP_OR,  OP_ORI:  begin src = RS_LOGIC; lfn = LF_OR;  end
            OP_XOR, OP_XORI: begin src = RS_LOGIC; lfn = LF_XOR; end
            OP_NOR:   begin src = RS_LOGIC; lfn = LF_NOR; end
            OP_SLL:   src = RS_SHIFT;
            OP_LUI:   src = RS_UPPER;
            default:  valid = 1'b0;
        endcase
    end

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .op        (op),
        .opnd_b    (opnd_b),
        .imm       (imm_val),
        .b_eff     (b_eff),
        .upper_val (upper_val)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a       (opnd_a),
        .b       (b_eff),
        .sub     (do_sub),
        .sum     (arith_y),
        .ovf_raw (ovf_raw)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a  (opnd_a),
        .b  (b_eff),
        .fn (lfn),
        .y  (logic_y)
    );

    alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
        .din    (opnd_b),
        .amount (shamt),
        .dout   (shift_y)
    );

    // Pick the result of the selected unit.
    always_comb begin
        unique case (src)
            RS_ARITH: result = arith_y;
            RS_LOGIC: result = logic_y;
            RS_SHIFT: result = shift_y;
            RS_UPPER: result = upper_val;
            default:  result = '0;
        endcase
    end

    // Flag overflow on trapping forms and withhold the write.
    always_comb begin
        ovf   = traps & ovf_raw;
        wr_en = valid & wr_req & ~ovf;
    end
endmodule

// File: rtl/ex_alu_unit_chk.sv
// Module: ex_alu_unit_chk
// Port-level checker bound to ex_alu_unit. Because the unit has no clock,
// the checks are immediate assertions. They run only when no input is
// unknown.
module ex_alu_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = $clog2(DATA_W)
) (
    input logic [4:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [IMM_W-1:0]  imm_val,
    input logic [SH_W-1:0]   shamt,
    input logic              wr_req,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              ovf
);
    logic known;
    logic trapping;
    logic unsigned_op;
    logic [DATA_W-1:0] low_mask;

    assign known = !$isunknown({op_sel, opnd_a, opnd_b, imm_val, shamt, wr_req});
    assign trapping    = (op_sel == 5'd1) || (op_sel == 5'd3) || (op_sel == 5'd10);
    assign unsigned_op = (op_sel == 5'd2) || (op_sel == 5'd4) || (op_sel == 5'd11);
    assign low_mask    = (DATA_W'(1) << shamt) - DATA_W'(1);

    // Port-level consistency checks.
    always_comb begin
        if (known) begin
            assert_ovf_blocks_write_R3: assert (!(ovf && wr_en))
                else $error("overflow with write enabled");
            assert_ovf_only_trapping_R4: assert (!ovf || trapping)
                else $error("overflow on non-trapping op %0d", op_sel);
            assert_no_overflow_R5: assert (!unsigned_op || (!ovf && (wr_en == wr_req)))
                else $error("unsigned op flagged or write changed");
            assert_sll_low_zero_R9: assert (op_sel != 5'd9 || ((result & low_mask) == '0))
                else $error("sll low bits not zero");
            assert_lui_low_zero_R10: assert (op_sel != 5'd15 || (result[DATA_W-IMM_W-1:0] == '0))
                else $error("lui low half not zero");
            assert_unknown_op_R11: assert (!(op_sel == 5'd0 || op_sel >= 5'd16)
                                           || (result == '0 && !wr_en && !ovf))
                else $error("unrecognised op produced output");
        end
    end
endmodule

bind ex_alu_unit ex_alu_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .imm_val (imm_val),
    .shamt   (shamt),
    .wr_req  (wr_req),
    .result  (result),
    .wr_en   (wr_en),
    .ovf     (ovf)
);

// File: tb/ex_alu_unit_tb.sv
`timescale 1ns/1ps
// Bench: directed scenario tasks against an independent 64-bit reference.
module ex_alu_unit_tb;
    logic        clk = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm_val = '0;
    logic [4:0]  shamt = '0;
    logic        wr_req = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    ex_alu_unit u_dut (
        .op_sel (op_sel), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .imm_val(imm_val), .shamt (shamt), .wr_req (wr_req),
        .result (result), .wr_en (wr_en), .ovf (ovf)
    );

    // Reference model written from the requirements.
    task automatic ref_calc(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                            input logic [15:0] im, input logic [4:0] sh, input logic rq,
                            output logic [31:0] r, output logic we, output logic ov);
        longint sa, sb, s;
        logic [31:0] ze, se;
        ze = {16'h0, im};
        se = {{16{im[15]}}, im};
        sa = longint'($signed(a));
        r = 32'h0; ov = 1'b0; we = rq;
        case (op)
            5'd1, 5'd2, 5'd10, 5'd11: begin
                sb = (op >= 5'd10) ? longint'($signed(se)) : longint'($signed(b));
                s  = sa + sb;
                r  = s[31:0];
                if ((op == 5'd1 || op == 5'd10) && (s > 64'sd2147483647 || s < -64'sd2147483648)) ov = 1'b1;
            end
            5'd3, 5'd4: begin
                s = sa - longint'($signed(b));
                r = s[31:0];
                if (op == 5'd3 && (s > 64'sd2147483647 || s < -64'sd2147483648)) ov = 1'b1;
            end
            5'd5:  r = a & b;
            5'd6:  r = a | b;
            5'd7:  r = a ^ b;
            5'd8:  r = ~(a | b);
            5'd9:  r = b << sh;
            5'd12: r = a & ze;
            5'd13: r = a | ze;
            5'd14: r = a ^ ze;
            5'd15: r = {im, 16'h0};
            default: we = 1'b0;
        endcase
        if (ov) we = 1'b0;
    endtask

    // Apply one vector, wait, and compare all three outputs.
    task automatic apply_check(input string req, input logic [4:0] op, input logic [31:0] a,
                               input logic [31:0] b, input logic [15:0] im,
                               input logic [4:0] sh, input logic rq);
        logic [31:0] er; logic ew, eo;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; imm_val = im; shamt = sh; wr_req = rq;
        @(posedge clk); #1;
        ref_calc(op, a, b, im, sh, rq, er, ew, eo);
        total++;
        if (result !== er || wr_en !== ew || ovf !== eo) begin
            bad++;
            $display("FAIL %s op=%0d: got r=%h we=%b ov=%b expected r=%h we=%b ov=%b",
                     req, op, result, wr_en, ovf, er, ew, eo);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    task automatic t_reset_state();  // R11: idle inputs give nothing
        apply_check("R11", 5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 1'b0);
    endtask

    task automatic t_add();  // R1, R3
        apply_check("R1", 5'd1, 32'd5, 32'd7, 16'h0, 5'd0, 1'b1);
        apply_check("R1", 5'd2, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R3", 5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R3", 5'd1, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0, 1'b1);
        apply_check("R3", 5'd1, 32'h7FFF_FFFE, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R3", 5'd1, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, 1'b1);
    endtask

    task automatic t_sub();  // R2, R4
        apply_check("R2", 5'd3, 32'd10, 32'd3, 16'h0, 5'd0, 1'b1);
        apply_check("R2", 5'd4, 32'd0, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R4", 5'd3, 32'h8000_0000, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R4", 5'd3, 32'h0, 32'h8000_0000, 16'h0, 5'd0, 1'b1);
        apply_check("R4", 5'd3, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, 1'b1);
        apply_check("R4", 5'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 1'b1);
    endtask

    task automatic t_unsigned();  // R5: same boundary pairs, no flag
        apply_check("R5", 5'd2, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R5", 5'd4, 32'h8000_0000, 32'd1, 16'h0, 5'd0, 1'b1);
        apply_check("R5", 5'd4, 32'h0, 32'h8000_0000, 16'h0, 5'd0, 1'b0);
        apply_check("R5", 5'd11, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 1'b1);
    endtask

    task automatic t_logic();  // R6
        apply_check("R6", 5'd5, 32'hF0F0_1234, 32'hFF00_00FF, 16'h0, 5'd0, 1'b1);
        apply_check("R6", 5'd6, 32'hF0F0_1234, 32'h0F00_00FF, 16'h0, 5'd0, 1'b1);
        apply_check("R6", 5'd7, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0, 1'b1);
        apply_check("R6", 5'd8, 32'h0000_00F0, 32'h0F00_0000, 16'h0, 5'd0, 1'b1);
    endtask

    task automatic t_logic_imm();  // R7: opnd_b is junk and must be ignored
        apply_check("R7", 5'd12, 32'hFFFF_FFFF, 32'h1234_5678, 16'h8F0F, 5'd0, 1'b1);
        apply_check("R7", 5'd13, 32'h0000_0000, 32'hDEAD_BEEF, 16'hF000, 5'd0, 1'b1);
        apply_check("R7", 5'd14, 32'hFFFF_FFFF, 32'hCAFE_F00D, 16'h8001, 5'd0, 1'b1);
    endtask

    task automatic t_arith_imm();  // R8, R3 through the immediate
        apply_check("R8", 5'd10, 32'd100, 32'hDEAD_BEEF, 16'hFFFF, 5'd0, 1'b1);
        apply_check("R8", 5'd11, 32'd0, 32'h1111_1111, 16'h8000, 5'd0, 1'b1);
        apply_check("R8", 5'd10, 32'h8000_0000, 32'h0, 16'h8000, 5'd0, 1'b1);
        apply_check("R8", 5'd10, 32'h7FFF_0000, 32'h0, 16'h7FFF, 5'd0, 1'b1);
        apply_check("R3", 5'd10, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 1'b1);
    endtask

    task automatic t_shift();  // R9: every shift count
        for (int s = 0; s < 32; s++)
            apply_check("R9", 5'd9, 32'hFFFF_FFFF, 32'h8000_0001 ^ s, 16'h0, 5'(s), 1'b1);
    endtask

    task automatic t_lui();  // R10
        apply_check("R10", 5'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hBEEF, 5'd7, 1'b1);
        apply_check("R10", 5'd15, 32'h0, 32'h0, 16'h0001, 5'd0, 1'b1);
    endtask

    task automatic t_invalid();  // R11
        apply_check("R11", 5'd0, 32'h7FFF_FFFF, 32'd1, 16'hFFFF, 5'd3, 1'b1);
        apply_check("R11", 5'd16, 32'h1234_5678, 32'h1, 16'h1, 5'd1, 1'b1);
        apply_check("R11", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31, 1'b1);
    endtask

    task automatic t_write_req();  // R12
        apply_check("R12", 5'd6, 32'h1, 32'h2, 16'h0, 5'd0, 1'b0);
        apply_check("R12", 5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, 1'b0);
        apply_check("R12", 5'd15, 32'h0, 32'h0, 16'h1234, 5'd0, 1'b0);
    endtask

    task automatic t_sweep();  // R1, R12: mixed operations on pseudo-random data
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            rng = next_rng(rng); a = rng;
            rng = next_rng(rng); b = rng;
            rng = next_rng(rng);
            apply_check("R1", rng[4:0], a, b, rng[20:5], rng[25:21], rng[31]);
        end
    endtask

    initial begin
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_add();
        t_sub();
        t_unsigned();
        t_logic();
        t_logic_imm();
        t_arith_imm();
        t_shift();
        t_lui();
        t_invalid();
        t_write_req();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule